// File: doc/BRIEF.md
# SPI Port With Control-Status Register

This block is a byte-wide serial peripheral interface (SPI) controller. A processor reaches it through a small register bus with three addresses: a control/status byte, a data byte and a configuration byte. The block can run as the bus master, generating SCK from the system clock. It can also run as a slave that follows an external SCK. Writes to the data address fill a one-byte transmit buffer, which feeds an 8-bit shift register. Each finished byte goes to a one-byte receive buffer. Reading the data address returns that byte and marks the buffer as read.

The status flags are sticky. Hardware sets them and only software clears them. A transfer-complete flag, a mode-fault flag and a slave overrun flag drive the interrupt line. A write-collision flag records data writes that were refused. The select pin can work in three ways, chosen by a two-bit field: it can be ignored (3-wire), sampled as an input (4-wire slave or multi-master), or driven as an output that follows a control bit (4-wire single master). In multi-master use, a low select pin while master mode is on is taken as a mode fault. The block then leaves master mode.

Top module: `spi_port`

## Requirements
- R1: After reset the control/status byte (address 0) reads 0x06 (select mode 01, transmit buffer empty, port off). The configuration byte (address 2, bit 0 = master enable) reads 0x00, irq is low, and no pin output enable is asserted.
- R2: In the control/status byte, bit 7 is transfer complete, bit 6 write collision, bit 5 mode fault and bit 4 receive overrun. A software write of 0 to any of these bits clears it, and a write of 1 leaves it unchanged. Bit 1 (transmit buffer empty) is read-only and ignores writes. Bits 3:2 (select mode) and bit 0 (port on) are writable. Once set, the transfer-complete flag stays set until software clears it.
- R3: In master mode (port on, master enable set), a byte leaves the transmit buffer as soon as the shifter is idle. It is sent MSB first in SPI mode 0: SCK idles low, each bit is sampled on the rising edge, and SCK has a period of 2*HALF_DIV system clocks. At the end, the byte received on MISO is placed in the receive buffer (address 1) and transfer complete is set.
- R4: Transmit buffer empty (bit 1) reads 0 in the cycle after a data write is accepted. It returns to 1 once the byte has been moved into the shift register.
- R5: A data write while the transmit buffer still holds a byte sets write collision (bit 6), and the write is discarded. The byte already in the buffer is the one transmitted later.
- R6: With select mode 01, port on and master enable set, a low select input sets mode fault (bit 5). It also clears master enable, stops SCK and MOSI being driven, and abandons any transfer in progress.
- R7: As a slave, the block samples MOSI on rising SCK and shifts on falling SCK. MISO presents the MSB of the loaded transmit byte. After eight bits the byte goes to the receive buffer and transfer complete is set.
- R8: Receive overrun (bit 4) is set only in slave mode, when a byte completes while the receive buffer holds an unread byte. The unread byte is kept.
- R9: In select modes 10 and 11 the select pin is driven and equals mode bit 0. In modes 00 and 01 it is not driven. In mode 00 the slave ignores the select input.
- R10: irq is high exactly when the port is on and at least one of transfer complete, mode fault or receive overrun is set. Write collision alone does not raise irq.
- R11: While the port is off, no transfer starts, the transmit buffer keeps its byte, and no pin output enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control/status, 1 data, 2 configuration |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; on address 1 it marks the receive buffer read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for sck_out |
| mosi_in | input | 1 | Serial data in, slave mode |
| mosi_out | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Output enable for mosi_out |
| miso_in | input | 1 | Serial data in, master mode |
| miso_out | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Output enable for miso_out |
| nss_in | input | 1 | Select input |
| nss_out | output | 1 | Select output value |
| nss_oe | output | 1 | Output enable for nss_out |

## Verification
The assertions check on every cycle the local rules that hold whatever the stimulus. Flags stay sticky. A refused write leaves the transmit buffer unchanged. An accepted write fills the buffer. A mode fault drops master enable. SCK stays low while the shifter is idle. Nothing is driven while the port is off, and irq never rises with the port off.

Only the bench scenarios can show the end-to-end behaviour: the bit order and SCK period seen by an external slave, the bytes exchanged with an external master, overrun keeping the old byte, the select-pin modes, and which queued byte actually goes out after a collision.

// File: rtl/spi_port_pkg.sv
// Package: shared register addresses, bit positions and select modes for
// the SPI port. Assumes an 8-bit register bus.
package spi_port_pkg;
    localparam int REG_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_CFG  = 2'd2;

    localparam int BIT_DONE  = 7;
    localparam int BIT_WCOL  = 6;
    localparam int BIT_FAULT = 5;
    localparam int BIT_OVR   = 4;
    localparam int BIT_MODE1 = 3;
    localparam int BIT_MODE0 = 2;
    localparam int BIT_TXMT  = 1;
    localparam int BIT_ON    = 0;

    typedef enum logic [1:0] {
        SEL_3WIRE  = 2'b00,
        SEL_INPUT  = 2'b01,
        SEL_DRV_LO = 2'b10,
        SEL_DRV_HI = 2'b11
    } sel_mode_e;
endpackage

// File: rtl/spi_port_sync.sv
// Module: two-flop synchronizer for asynchronous pin inputs.
// Assumes each bit is independent; RST_VAL gives the idle level per bit.
module spi_port_sync #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic meta_q;
            logic sync_q;
            // Two-stage capture of one pin bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[gi];
                    sync_q <= RST_VAL[gi];
                end else begin
                    meta_q <= d_in[gi];
                    sync_q <= meta_q;
                end
            end
            assign d_out[gi] = sync_q;
        end
    endgenerate
endmodule

// File: rtl/spi_port_regs.sv
// Module: register file of the SPI port. Holds the control/status flags,
// select mode, port-on bit, master enable, transmit and receive buffers.
// Assumes xfer_done is a single-cycle pulse with rx_byte valid in that cycle
// and that load is asserted only while tx_full is high.
module spi_port_regs
    import spi_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             xfer_done,
    input  logic [WIDTH-1:0] rx_byte,
    input  logic             fault_hit,
    input  logic             load,
    output logic             port_on,
    output logic             master_en,
    output logic [1:0]       sel_mode,
    output logic             tx_full,
    output logic [WIDTH-1:0] tx_buf,
    output logic             flag_done,
    output logic             flag_wcol,
    output logic             flag_fault,
    output logic             flag_ovr
);
    logic             wr_ctrl, wr_data, wr_cfg, rd_data;
    logic             rx_full;
    logic [WIDTH-1:0] rx_buf;
    logic             rx_pending;
    logic             rx_take;

    assign wr_ctrl    = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_data    = bus_wr && (bus_addr == ADDR_DATA);
    assign wr_cfg     = bus_wr && (bus_addr == ADDR_CFG);
    assign rd_data    = bus_rd && (bus_addr == ADDR_DATA);
    // A read in the same cycle frees the buffer for the incoming byte.
    assign rx_pending = rx_full && !rd_data;
    assign rx_take    = xfer_done && (master_en || !rx_pending);

    // Sticky flags: hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_done  <= 1'b0;
            flag_wcol  <= 1'b0;
            flag_fault <= 1'b0;
            flag_ovr   <= 1'b0;
        end else begin
            if (xfer_done)
                flag_done <= 1'b1;
            else if (wr_ctrl && !bus_wdata[BIT_DONE])
                flag_done <= 1'b0;

            if (wr_data && tx_full)
                flag_wcol <= 1'b1;
            else if (wr_ctrl && !bus_wdata[BIT_WCOL])
                flag_wcol <= 1'b0;

            if (fault_hit)
                flag_fault <= 1'b1;
            else if (wr_ctrl && !bus_wdata[BIT_FAULT])
                flag_fault <= 1'b0;

            if (xfer_done && !master_en && rx_pending)
                flag_ovr <= 1'b1;
            else if (wr_ctrl && !bus_wdata[BIT_OVR])
                flag_ovr <= 1'b0;
        end
    end

    // Writable control fields: select mode and port-on bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_mode <= SEL_INPUT;
            port_on  <= 1'b0;
        end else if (wr_ctrl) begin
            sel_mode <= bus_wdata[BIT_MODE1:BIT_MODE0];
            port_on  <= bus_wdata[BIT_ON];
        end
    end

    // Master enable: software sets it, a mode fault drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            master_en <= 1'b0;
        else if (fault_hit)
            master_en <= 1'b0;
        else if (wr_cfg)
            master_en <= bus_wdata[0];
    end

    // Transmit buffer: accepts a write only when empty, empties on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_full <= 1'b0;
            tx_buf  <= '0;
        end else if (wr_data && !tx_full) begin
            tx_full <= 1'b1;
            tx_buf  <= bus_wdata[WIDTH-1:0];
        end else if (load) begin
            tx_full <= 1'b0;
        end
    end

    // Receive buffer: filled on completion, freed by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            rx_buf  <= '0;
        end else if (rx_take) begin
            rx_full <= 1'b1;
            rx_buf  <= rx_byte;
        end else if (rd_data) begin
            rx_full <= 1'b0;
        end
    end

    // Read multiplexer for the register bus.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {flag_done, flag_wcol, flag_fault, flag_ovr,
                                    sel_mode, !tx_full, port_on};
            ADDR_DATA: bus_rdata[WIDTH-1:0] = rx_buf;
            ADDR_CFG:  bus_rdata[0] = master_en;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_port_engine.sv
// Module: shift engine. As master it generates SCK (mode 0, period
// 2*HALF_DIV clocks); as slave it follows synchronized SCK edges.
// Assumes slave inputs are already synchronized; abort clears all state.
module spi_port_engine #(
    parameter int WIDTH    = 8,
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_on,
    input  logic             master,
    input  logic             slave_sel,
    input  logic             abort,
    input  logic             tx_valid,
    input  logic [WIDTH-1:0] tx_data,
    output logic             load,
    input  logic             sck_s,
    input  logic             mosi_s,
    input  logic             miso_raw,
    output logic             sck_q,
    output logic             out_bit,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] rx_byte
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);
    localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(HALF_DIV - 1);

    logic [WIDTH-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] div;
    logic             samp;
    logic             loaded;
    logic             sck_prev;
    logic             run;
    logic             rise_s, fall_s;
    logic             load_m, load_s;

    assign run     = port_on && !abort;
    assign rise_s  = sck_s && !sck_prev;
    assign fall_s  = !sck_s && sck_prev;
    assign load_m  = run && master && !busy && tx_valid;
    assign load_s  = run && !master && slave_sel && !busy && !loaded && tx_valid;
    assign load    = load_m || load_s;
    assign out_bit = shreg[WIDTH-1];
    assign rx_byte = shreg;

    // Edge history of the synchronized slave clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sck_prev <= 1'b0;
        else
            sck_prev <= sck_s;
    end

    // Shift state machine for both roles.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            shreg  <= '0;
            cnt    <= '0;
            div    <= '0;
            samp   <= 1'b0;
            sck_q  <= 1'b0;
            busy   <= 1'b0;
            loaded <= 1'b0;
            done   <= 1'b0;
        end else if (master) begin
            done   <= 1'b0;
            loaded <= 1'b0;
            if (!busy) begin
                sck_q <= 1'b0;
                div   <= '0;
                cnt   <= '0;
                if (tx_valid) begin
                    shreg <= tx_data;
                    busy  <= 1'b1;
                end
            end else if (div == DIV_END) begin
                div   <= '0;
                sck_q <= !sck_q;
                if (!sck_q) begin
                    samp <= miso_raw;
                end else begin
                    shreg <= {shreg[WIDTH-2:0], samp};
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST_BIT) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        cnt  <= '0;
                    end
                end
            end else begin
                div <= div + 1'b1;
            end
        end else begin
            done  <= 1'b0;
            sck_q <= 1'b0;
            div   <= '0;
            if (!slave_sel) begin
                cnt  <= '0;
                busy <= 1'b0;
            end else begin
                if (load_s) begin
                    shreg  <= tx_data;
                    loaded <= 1'b1;
                end
                if (rise_s) begin
                    samp <= mosi_s;
                    busy <= 1'b1;
                end
                if (fall_s && busy) begin
                    shreg <= {shreg[WIDTH-2:0], samp};
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST_BIT) begin
                        busy   <= 1'b0;
                        done   <= 1'b1;
                        loaded <= 1'b0;
                        cnt    <= '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_port.sv
// Module: SPI port top. Ties the register file, pin synchronizers and
// shift engine together and derives pin enables, select output and irq.
// Assumes the pins are external, asynchronous to clk except miso_in, which
// the master samples directly.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    input  logic       sck_in,
    output logic       sck_out,
    output logic       sck_oe,
    input  logic       mosi_in,
    output logic       mosi_out,
    output logic       mosi_oe,
    input  logic       miso_in,
    output logic       miso_out,
    output logic       miso_oe,
    input  logic       nss_in,
    output logic       nss_out,
    output logic       nss_oe
);
    localparam int WIDTH = REG_W;

    logic             port_on, master_en, tx_full, load, busy, done;
    logic [1:0]       sel_mode;
    logic [WIDTH-1:0] tx_buf, rx_byte;
    logic             flag_done, flag_wcol, flag_fault, flag_ovr;
    logic             sck_s, mosi_s, nss_s;
    logic [2:0]       pins_s;
    logic             fault_hit, slave_sel, shift_msb, sck_q;

    spi_port_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({nss_in, mosi_in, sck_in}),
        .d_out (pins_s)
    );
    assign sck_s  = pins_s[0];
    assign mosi_s = pins_s[1];
    assign nss_s  = pins_s[2];

    assign fault_hit = port_on && master_en && (sel_mode == SEL_INPUT) && !nss_s;
    assign slave_sel = (sel_mode != SEL_INPUT) || !nss_s;

    spi_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .xfer_done  (done),
        .rx_byte    (rx_byte),
        .fault_hit  (fault_hit),
        .load       (load),
        .port_on    (port_on),
        .master_en  (master_en),
        .sel_mode   (sel_mode),
        .tx_full    (tx_full),
        .tx_buf     (tx_buf),
        .flag_done  (flag_done),
        .flag_wcol  (flag_wcol),
        .flag_fault (flag_fault),
        .flag_ovr   (flag_ovr)
    );

    spi_port_engine #(.WIDTH(WIDTH), .HALF_DIV(HALF_DIV)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_on   (port_on),
        .master    (master_en),
        .slave_sel (slave_sel),
        .abort     (fault_hit),
        .tx_valid  (tx_full),
        .tx_data   (tx_buf),
        .load      (load),
        .sck_s     (sck_s),
        .mosi_s    (mosi_s),
        .miso_raw  (miso_in),
        .sck_q     (sck_q),
        .out_bit   (shift_msb),
        .busy      (busy),
        .done      (done),
        .rx_byte   (rx_byte)
    );

    // Pin drive: master owns SCK/MOSI, a selected slave owns MISO.
    always_comb begin
        sck_out  = sck_q;
        mosi_out = shift_msb;
        miso_out = shift_msb;
        sck_oe   = port_on && master_en;
        mosi_oe  = port_on && master_en;
        miso_oe  = port_on && !master_en && slave_sel;
        nss_out  = sel_mode[0];
        nss_oe   = port_on && sel_mode[1];
        irq      = port_on && (flag_done || flag_fault || flag_ovr);
    end
endmodule

// File: rtl/spi_port_chk.sv
// Module: assertion checker for the SPI port, bound into the top.
// Assumes it observes the top's internal register-file and engine nets.
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       port_on,
    input logic       master_en,
    input logic       tx_full,
    input logic [7:0] tx_buf,
    input logic       flag_done,
    input logic       flag_wcol,
    input logic       flag_fault,
    input logic       fault_hit,
    input logic       busy,
    input logic       sck_out,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       miso_oe,
    input logic       nss_oe,
    input logic       irq
);
    logic wr_ctrl, wr_data;
    assign wr_ctrl = bus_wr && (bus_addr == 2'd0);
    assign wr_data = bus_wr && (bus_addr == 2'd1);

    // R2: transfer-complete flag only clears on a software write of 0.
    a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_done && !(wr_ctrl && !bus_wdata[7])) |=> flag_done);

    // R3: SCK stays low while the shifter is idle.
    a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_out);

    // R4: an accepted data write fills the transmit buffer.
    a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !tx_full) |=> tx_full);

    // R5: a colliding write keeps the buffer and flags the collision.
    a_r5_wcol_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_full) |=> (tx_buf == $past(tx_buf)) && flag_wcol);

    // R6: a mode fault records the flag and drops master enable.
    a_r6_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |=> (flag_fault && !master_en));

    // R10: interrupt never asserted while the port is off.
    a_r10_irq_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> port_on);

    // R11: no pin is driven while the port is off.
    a_r11_pins_off: assert property (@(posedge clk) disable iff (!rst_n)
        !port_on |-> !(sck_oe || mosi_oe || miso_oe || nss_oe));
endmodule

bind spi_port spi_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .port_on    (port_on),
    .master_en  (master_en),
    .tx_full    (tx_full),
    .tx_buf     (tx_buf),
    .flag_done  (flag_done),
    .flag_wcol  (flag_wcol),
    .flag_fault (flag_fault),
    .fault_hit  (fault_hit),
    .busy       (busy),
    .sck_out    (sck_out),
    .sck_oe     (sck_oe),
    .mosi_oe    (mosi_oe),
    .miso_oe    (miso_oe),
    .nss_oe     (nss_oe),
    .irq        (irq)
);

// File: tb/spi_port_bench.sv
// Directed bench for the SPI port: one task per scenario, each self-checking.
module spi_port_bench;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       sck_in = 1'b0;
    logic       sck_out, sck_oe;
    logic       mosi_in = 1'b0;
    logic       mosi_out, mosi_oe;
    logic       miso_in;
    logic       miso_out, miso_oe;
    logic       nss_in = 1'b1;
    logic       nss_out, nss_oe;

    int checks = 0;
    int failures = 0;

    // External slave model used when the port is master.
    logic [7:0] ext_sreg = 8'h00;
    logic [7:0] ext_cap = 8'h00;
    logic       ext_prev = 1'b0;
    int         rises = 0;
    int         since_rise = 0;
    int         last_period = 0;

    always #5 clk = !clk;

    spi_port #(.HALF_DIV(HALF)) u_spi_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .nss_in(nss_in), .nss_out(nss_out), .nss_oe(nss_oe)
    );

    assign miso_in = ext_sreg[7];

    // Slave model: capture MOSI on rising SCK, advance MISO on falling SCK.
    always @(negedge clk) begin
        since_rise <= since_rise + 1;
        if (sck_out && !ext_prev) begin
            ext_cap     <= {ext_cap[6:0], mosi_out};
            rises       <= rises + 1;
            last_period <= since_rise;
            since_rise  <= 1;
        end
        if (!sck_out && ext_prev)
            ext_sreg <= {ext_sreg[6:0], 1'b0};
        ext_prev <= sck_out;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Look at a register in the current cycle without a read strobe.
    task automatic reg_peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        logic [7:0] s;
        ok = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            reg_peek(2'd0, s);
            if (s[7]) begin ok = 1'b1; break; end
        end
    endtask

    // External master driving one byte into the slave port, mode 0.
    task automatic ext_master_byte(input logic [7:0] b, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            mosi_in = b[i];
            repeat (6) @(negedge clk);
            got[i] = miso_out;
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
            sck_in = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        reg_peek(2'd0, d);
        check("R1 ctrl reset", d, 8'h06);
        reg_peek(2'd2, d);
        check("R1 cfg reset", d, 8'h00);
        check("R1 irq reset", irq, 0);
        check("R1 pins undriven", {sck_oe, mosi_oe, miso_oe, nss_oe}, 0);
    endtask

    task automatic t_disabled_and_wcol;
        logic [7:0] d;
        bit ok;
        reg_write(2'd0, 8'h04);          // port off, mode 01
        reg_write(2'd2, 8'h01);
        reg_write(2'd1, 8'h11);
        reg_peek(2'd0, d);
        check("R4 txbmt low after write", d[1], 0);
        reg_write(2'd1, 8'h22);          // collides
        reg_peek(2'd0, d);
        check("R5 wcol set", d[6], 1);
        check("R10 wcol alone no irq", irq, 0);
        repeat (40) @(negedge clk);
        check("R11 no sck while off", sck_out, 0);
        check("R11 pins undriven while off", {sck_oe, mosi_oe, miso_oe, nss_oe}, 0);
        reg_peek(2'd0, d);
        check("R11 buffer held while off", d[1], 0);
        ext_sreg = 8'h96;
        rises = 0;
        reg_write(2'd0, 8'h41);          // on, mode 00, keep wcol
        wait_done(ok);
        check("R3 transfer completes", ok, 1);
        check("R5 first byte sent", ext_cap, 8'h11);
        reg_read(2'd1, d);
        check("R3 byte received", d, 8'h96);
        check("R10 irq on done", irq, 1);
        reg_write(2'd0, 8'h41);          // clear done, keep wcol
        reg_peek(2'd0, d);
        check("R2 write1 keeps wcol, write0 clears done", d, 8'h43);
        check("R10 irq low with only wcol", irq, 0);
        reg_write(2'd0, 8'h03);          // bit1 written, clear wcol
        reg_peek(2'd0, d);
        check("R2 txbmt read-only, wcol cleared", d, 8'h03);
    endtask

    task automatic t_master_xfer;
        logic [7:0] d;
        bit ok;
        reg_write(2'd0, 8'h0D);          // on, mode 11
        reg_write(2'd2, 8'h01);
        check("R9 nss driven high", {nss_oe, nss_out}, 2'b11);
        ext_sreg = 8'h3C;
        rises = 0;
        reg_write(2'd1, 8'hA5);
        reg_peek(2'd0, d);
        check("R4 txbmt low right after write", d[1], 0);
        @(negedge clk);
        reg_peek(2'd0, d);
        check("R4 txbmt back once loaded", d[1], 1);
        check("R3 sck driven", sck_oe & mosi_oe, 1);
        wait_done(ok);
        check("R3 done flag", ok, 1);
        check("R3 MSB-first on MOSI", ext_cap, 8'hA5);
        check("R3 eight sck rises", rises, 8);
        check("R3 sck period", last_period, 2 * HALF);
        reg_read(2'd1, d);
        check("R3 MISO byte", d, 8'h3C);
        repeat (20) @(negedge clk);
        reg_peek(2'd0, d);
        check("R2 done stays set", d[7], 1);
        reg_write(2'd0, 8'h09);          // clear done, mode 10
        check("R9 nss driven low", {nss_oe, nss_out}, 2'b10);
        check("R10 irq low after clear", irq, 0);
        reg_write(2'd0, 8'h05);          // mode 01
        check("R9 nss undriven in 01", nss_oe, 0);
    endtask

    task automatic t_fault;
        logic [7:0] d;
        nss_in = 1'b1;
        reg_write(2'd0, 8'h05);
        reg_write(2'd2, 8'h01);
        repeat (4) @(negedge clk);
        check("R6 no fault while nss high", irq, 0);
        nss_in = 1'b0;
        repeat (5) @(negedge clk);
        reg_peek(2'd0, d);
        check("R6 fault flag", d[5], 1);
        reg_peek(2'd2, d);
        check("R6 master dropped", d, 8'h00);
        check("R6 sck/mosi released", {sck_oe, mosi_oe}, 0);
        check("R10 irq on fault", irq, 1);
        nss_in = 1'b1;
        reg_write(2'd0, 8'h05);
        check("R2 fault cleared by write0", irq, 0);
    endtask

    task automatic t_slave;
        logic [7:0] d, got;
        bit ok;
        reg_write(2'd2, 8'h00);
        reg_write(2'd0, 8'h05);          // mode 01, on
        nss_in = 1'b0;
        reg_write(2'd1, 8'h5A);
        repeat (6) @(negedge clk);
        check("R7 miso driven when selected", miso_oe, 1);
        ext_master_byte(8'hC3, got);
        check("R7 slave sent byte", got, 8'h5A);
        reg_peek(2'd0, d);
        check("R7 done flag as slave", d[7], 1);
        check("R8 no overrun yet", d[4], 0);
        ext_master_byte(8'h81, got);
        reg_peek(2'd0, d);
        check("R8 overrun set", d[4], 1);
        reg_read(2'd1, d);
        check("R8 unread byte kept", d, 8'hC3);
        reg_write(2'd0, 8'h01);          // clear flags, mode 00
        check("R10 irq low after clear", irq, 0);
        nss_in = 1'b1;
        ext_master_byte(8'h77, got);
        ok = 1'b1;
        reg_peek(2'd0, d);
        check("R9 mode 00 ignores nss", d[7], 1);
        check("R8 no overrun after read", d[4], 0);
        reg_read(2'd1, d);
        check("R7 mode 00 received", d, 8'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled_and_wcol();
        t_master_xfer();
        t_fault();
        t_slave();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule